// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio of 16·N + A. It is the feedback-side divider of a frequency synthesizer loop, and its output pulse goes to the phase comparator. A prescaler counts input clocks with a modulus of either 16 or 17. A 4-bit swallow counter holds the prescaler at 17 for the first A prescaler cycles of each output period. A 14-bit main counter ends the period after N prescaler cycles in total.

All state is synchronous to the input clock. Each enabled clock edge counts as one input cycle. When the run enable is low, every counter holds its value. The ratio settings come from the programming interface and are sampled only at a period boundary, so a period is never shortened or stretched by a change in the settings. At that boundary a pair with N not greater than A is refused, and the divider keeps the pair it already uses.

Top module: `psw_divider`

## Requirements
- R1: With `run_en` held high, consecutive `div_pulse` assertions are exactly 16·N + A clock cycles apart, where N and A are the pair adopted at the start of that period.
- R2: Synchronous reset clears `div_pulse`. It restores the reset pair (default N = 17, A = 0), whatever `n_set`/`a_set` hold, so the first pulse after reset release arrives 272 enabled cycles later.
- R3: `div_pulse` is high for exactly one clock cycle per period, on the cycle after the last input cycle of the period.
- R4: While `run_en` is low, no counter advances and `div_pulse` stays low. Stopping for S cycles lengthens the current period to 16·N + A + S cycles.
- R5: `n_set`/`a_set` are sampled only on the clock edge that ends a period, which is the edge that raises `div_pulse`. A change in the middle of a period does not alter that period.
- R6: A pair sampled at a boundary with `n_set` ≤ `a_set` is ignored, and the previously adopted pair stays in force. The adopted pair always satisfies A < N.
- R7: Within a period the prescaler uses modulus 17 for the first A prescaler cycles and modulus 16 for the remaining N − A cycles.
- R8: With A = 0 the ratio is exactly 16·N. With the smallest legal N = 1 the period is 16 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counting enable; low freezes the divider |
| n_set | input | 14 | Main-counter value N requested by the programming side |
| a_set | input | 4 | Swallow-counter value A requested by the programming side |
| div_pulse | output | 1 | Registered one-cycle pulse at the end of each divided period |

## Verification
`div_pulse` is registered, so it rises one edge after the terminal input cycle. Every gap is therefore counted on falling edges, from the falling edge where one pulse is seen to the falling edge where the next one is seen. That count equals the number of enabled edges in the period plus any stopped cycles. Because a settings pair is adopted on the pulse edge itself, values written right after a pulse govern the second gap and not the first. The bench checks the first gap against the old ratio and the second against the new one. The reset case counts from the falling edge that releases reset, so the count lands on 272.

// File: rtl/psw_pkg.sv
package psw_pkg;

  // Prescaler modulus selection: base (2**A_W) or base + 1.
  typedef enum logic {
    MOD_BASE = 1'b0,
    MOD_EXT  = 1'b1
  } psw_mod_e;

endpackage

// File: rtl/psw_cfg_latch.sv
module psw_cfg_latch #(
  parameter int N_W   = 14,
  parameter int A_W   = 4,
  parameter int N_RST = 17,
  parameter int A_RST = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           boundary,
  input  logic [N_W-1:0] n_in,
  input  logic [A_W-1:0] a_in,
  output logic [N_W-1:0] n_next,
  output logic [A_W-1:0] a_next
);

  localparam logic [N_W-1:0] N_INIT = N_W'(N_RST);
  localparam logic [A_W-1:0] A_INIT = A_W'(A_RST);

  logic [N_W-1:0] n_act;
  logic [A_W-1:0] a_act;
  logic           pair_ok;

  // Accept a pair only when N strictly exceeds A.
  always_comb begin
    pair_ok = ({{(N_W-A_W){1'b0}}, a_in} < n_in);
    n_next  = pair_ok ? n_in : n_act;
    a_next  = pair_ok ? a_in : a_act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_act <= N_INIT;
      a_act <= A_INIT;
    end else if (boundary) begin
      n_act <= n_next;
      a_act <= a_next;
    end
  end

  // R6: the adopted pair is always legal
  a_r6_active_legal: assert property (@(posedge clk) disable iff (rst)
    ({{(N_W-A_W){1'b0}}, a_act} < n_act));

  // R5: adopted pair moves only on a period boundary
  a_r5_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(n_act) && $stable(a_act)));

endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler
  import psw_pkg::*;
#(
  parameter int A_W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  psw_mod_e     mode,
  output logic         wrap,
  output logic [A_W:0] cnt_o
);

  localparam int          BASE     = 1 << A_W;
  localparam logic [A_W:0] LAST_BASE = (A_W+1)'(BASE - 1);
  localparam logic [A_W:0] LAST_EXT  = (A_W+1)'(BASE);

  logic [A_W:0] cnt;
  logic [A_W:0] last;

  always_comb begin
    last = (mode == MOD_EXT) ? LAST_EXT : LAST_BASE;
    wrap = en && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (en)   cnt <= cnt + 1'b1;
  end

  assign cnt_o = cnt;

  // R4: nothing advances while stopped
  a_r4_prescaler_frozen: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));

  // R7: count never goes past the extended modulus
  a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_EXT);

endmodule

// File: rtl/psw_swallow_ctr.sv
module psw_swallow_ctr #(
  parameter int A_W   = 4,
  parameter int A_RST = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           boundary,
  input  logic [A_W-1:0] a_load,
  output logic           busy
);

  logic [A_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= A_W'(A_RST);
    else if (boundary)               cnt <= a_load;
    else if (tick && (cnt != '0))    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R7: once exhausted, stays exhausted until the next boundary
  a_r7_swallow_monotone: assert property (@(posedge clk) disable iff (rst)
    (!busy && !boundary) |=> !busy);

endmodule

// File: rtl/psw_main_ctr.sv
module psw_main_ctr #(
  parameter int N_W   = 14,
  parameter int N_RST = 17
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [N_W-1:0] n_load,
  output logic           period_end
);

  logic [N_W-1:0] cnt;

  assign period_end = tick && (cnt == N_W'(1));

  always_ff @(posedge clk) begin
    if (rst)             cnt <= N_W'(N_RST);
    else if (period_end) cnt <= n_load;
    else if (tick)       cnt <= cnt - 1'b1;
  end

  // R1: the main count never reaches zero
  a_r1_main_nonzero: assert property (@(posedge clk) disable iff (rst)
    cnt != '0);

endmodule

// File: rtl/psw_divider.sv
module psw_divider
  import psw_pkg::*;
#(
  parameter int N_W   = 14,
  parameter int A_W   = 4,
  parameter int N_RST = 17,
  parameter int A_RST = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_en,
  input  logic [N_W-1:0] n_set,
  input  logic [A_W-1:0] a_set,
  output logic           div_pulse
);

  localparam logic [A_W:0] EXT_TOP = (A_W+1)'(1 << A_W);

  logic           pre_wrap;
  logic [A_W:0]   pre_cnt;
  logic           swallow_busy;
  logic           boundary;
  logic [N_W-1:0] n_next;
  logic [A_W-1:0] a_next;
  psw_mod_e       mode;

  assign mode = swallow_busy ? MOD_EXT : MOD_BASE;

  psw_cfg_latch #(.N_W(N_W), .A_W(A_W), .N_RST(N_RST), .A_RST(A_RST)) u_cfg (
    .clk(clk), .rst(rst), .boundary(boundary),
    .n_in(n_set), .a_in(a_set), .n_next(n_next), .a_next(a_next)
  );

  psw_prescaler #(.A_W(A_W)) u_pre (
    .clk(clk), .rst(rst), .en(run_en), .mode(mode),
    .wrap(pre_wrap), .cnt_o(pre_cnt)
  );

  psw_swallow_ctr #(.A_W(A_W), .A_RST(A_RST)) u_swallow (
    .clk(clk), .rst(rst), .tick(pre_wrap), .boundary(boundary),
    .a_load(a_next), .busy(swallow_busy)
  );

  psw_main_ctr #(.N_W(N_W), .N_RST(N_RST)) u_main (
    .clk(clk), .rst(rst), .tick(pre_wrap), .n_load(n_next),
    .period_end(boundary)
  );

  always_ff @(posedge clk) begin
    if (rst) div_pulse <= 1'b0;
    else     div_pulse <= boundary;
  end

  // R3: pulse is one cycle wide
  a_r3_one_wide: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R4: no pulse follows a stopped cycle
  a_r4_no_pulse_stopped: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !div_pulse);

  // R7: extended modulus count is reached only while swallowing
  a_r7_ext_only_swallow: assert property (@(posedge clk) disable iff (rst)
    (pre_cnt == EXT_TOP) |-> swallow_busy);

  // R1: a period ends only on a prescaler wrap
  a_r1_end_on_wrap: assert property (@(posedge clk) disable iff (rst)
    boundary |-> (pre_wrap && run_en));

endmodule

// File: tb/psw_divider_bench.sv
module psw_divider_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b1;
  logic [13:0] n_set = 14'd40;
  logic [3:0]  a_set = 4'd7;
  logic        div_pulse;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  psw_divider u_psw_divider (
    .clk(clk), .rst(rst), .run_en(run_en),
    .n_set(n_set), .a_set(a_set), .div_pulse(div_pulse)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge where div_pulse is high; counts to the next pulse.
  task automatic next_gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) check(!div_pulse, "R3", int'(div_pulse), 0);
    end while (!div_pulse);
  endtask

  task automatic gap_is(input int exp, input string req);
    int n;
    next_gap(n);
    check(n == exp, req, n, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(div_pulse == 1'b0, "R2", int'(div_pulse), 0);
    begin
      int n = 0;
      rst = 1'b0;
      do begin @(negedge clk); n++; end while (!div_pulse);
      check(n == 272, "R2", n, 272);
    end
    gap_is(16*40 + 7, "R1");
  endtask

  task automatic t_no_swallow;
    n_set = 14'd30; a_set = 4'd0;
    gap_is(16*40 + 7, "R5");
    gap_is(480, "R8");
  endtask

  task automatic t_full_swallow;
    n_set = 14'd16; a_set = 4'd15;
    gap_is(480, "R1");
    gap_is(271, "R7");
  endtask

  task automatic t_stop;
    int c = 0;
    n_set = 14'd20; a_set = 4'd5;
    gap_is(271, "R1");
    gap_is(325, "R1");
    for (int i = 0; i < 50; i++) begin @(negedge clk); c++; end
    run_en = 1'b0;
    for (int j = 0; j < 37; j++) begin
      @(negedge clk); c++;
      if (div_pulse) check(1'b0, "R4", 1, 0);
    end
    check(1'b1, "R4", 0, 0);
    run_en = 1'b1;
    do begin @(negedge clk); c++; end while (!div_pulse);
    check(c == 325 + 37, "R4", c, 325 + 37);
  endtask

  task automatic t_mid_change;
    int c = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); c++; end
    n_set = 14'd18; a_set = 4'd2;
    do begin @(negedge clk); c++; end while (!div_pulse);
    check(c == 325, "R5", c, 325);
    gap_is(290, "R5");
  endtask

  task automatic t_reject;
    n_set = 14'd3; a_set = 4'd3;
    gap_is(290, "R6");
    gap_is(290, "R6");
    n_set = 14'd5; a_set = 4'd9;
    gap_is(290, "R6");
    n_set = 14'd0; a_set = 4'd0;
    gap_is(290, "R6");
  endtask

  task automatic t_min_ratio;
    n_set = 14'd1; a_set = 4'd0;
    gap_is(290, "R1");
    gap_is(16, "R8");
    gap_is(16, "R8");
  endtask

  task automatic t_rerst;
    int n = 0;
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(div_pulse == 1'b0, "R2", int'(div_pulse), 0);
    end
    rst = 1'b0;
    do begin @(negedge clk); n++; end while (!div_pulse);
    check(n == 272, "R2", n, 272);
    gap_is(16, "R1");
  endtask

  initial begin
    t_reset();
    t_no_swallow();
    t_full_swallow();
    t_stop();
    t_mid_change();
    t_reject();
    t_min_ratio();
    t_rerst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule